// File: doc/BRIEF.md
# Triggered Circular IQ Capture Engine

This block records a stream of complex baseband samples into a window of on-chip memory that is used as a ring buffer. Software sets the capture enable, and the engine then writes one 64-bit word for every accepted sample. The write address wraps inside the selected window, so the ring always holds the most recent history. A single trigger event comes from one of six selectable sources and is detected on the chosen edge. After it, the engine writes a programmed number of further samples and stops. The rest of the ring keeps the samples from before the trigger. A trigger at the end of a frame can therefore still hold that frame's preamble.

Each word carries receive path A in its low half. In dual-path mode it also carries a second receive path in its high half, and both paths are taken from the same trigger. When the capture finishes, the engine asserts done and freezes its write pointer. Software reads that pointer and finds the newest sample just below it. If the ring has wrapped, the oldest sample sits at that address. If the sample source stays silent after the trigger, the capture never completes and busy stays high, so software sees a timeout and not a short record.

Top module: `iq_capture_eng`

## Requirements
- R1: After a synchronous active-high reset, st_busy and st_done are 0, st_wptr is 0 and mem_we is 0.
- R2: While idle, a high cfg_enable arms the engine. From the next cycle st_busy is 1 and the write pointer restarts at 0. The trigger source, edge, post count, window mode and path mode are captured at that moment, and later changes take no effect until the next arm.
- R3: Each cycle with smp_valid high while armed or counting post-trigger samples gives one write on the following cycle. mem_we is 1, mem_addr is WIN_BASE plus the pointer, and st_wptr then advances by one.
- R4: Path A I occupies word bits [11:0] and path A Q bits [23:12], as raw 12-bit two's complement values. In single-path mode every other bit is 0.
- R5: With cfg_dual_path high at arm, path B Q occupies bits [43:32] and path B I bits [55:44]. Bits [31:24] and [63:56] stay 0.
- R6: The window holds WIN_WORDS words (default 4096 words, 32 KB). With cfg_win_double high at arm it holds twice that many. The pointer wraps to 0 after the last word of the selected window.
- R7: cfg_trig_sel selects the trigger source. The codes are: 0 manual bit, 1 good-CRC frame end, 2 failed-CRC frame, 3 clear-channel event, 4 baseband event, 5 MAC event. Codes 6 and 7 never trigger. Events on sources that are not selected have no effect.
- R8: cfg_trig_falling = 0 triggers on a 0→1 change of the selected source, and 1 triggers on a 1→0 change.
- R9: A change of cfg_manual counts only in a cycle where the engine is already armed. A level that is already high when the engine arms does not trigger.
- R10: After the trigger, exactly the captured post count of further accepted samples are written. The engine then shows st_done = 1 and st_busy = 0, stops writing and holds st_wptr. With a post count of 0, done follows the trigger cycle directly.
- R11: If no sample is accepted after the trigger, st_busy stays 1 and st_done stays 0 without limit.
- R12: While done, further trigger events are ignored. Done holds until cfg_enable is cleared, which returns the engine to idle. Setting cfg_enable again re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Capture enable; rising from idle arms the engine |
| cfg_trig_sel | input | 3 | Trigger source code |
| cfg_trig_falling | input | 1 | Edge polarity: 0 rising, 1 falling |
| cfg_post_cnt | input | POST_W | Samples to write after the trigger |
| cfg_win_double | input | 1 | Doubles the ring window |
| cfg_dual_path | input | 1 | Packs path B into the upper dword |
| cfg_manual | input | 1 | Manual trigger bit |
| smp_valid | input | 1 | Sample strobe |
| smp_a_i | input | SW | Path A in-phase |
| smp_a_q | input | SW | Path A quadrature |
| smp_b_i | input | SW | Path B in-phase |
| smp_b_q | input | SW | Path B quadrature |
| ev_crc_ok | input | 1 | Good-CRC frame end event |
| ev_crc_fail | input | 1 | Failed-CRC frame event |
| ev_cca | input | 1 | Clear-channel assessment event |
| ev_bb | input | 1 | Baseband event |
| ev_mac | input | 1 | MAC event |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| st_busy | output | 1 | Armed or counting post-trigger samples |
| st_done | output | 1 | Capture complete |
| st_wptr | output | log2(2*WIN_WORDS) | Next write offset in the window, frozen at done |

## Verification
A wrong internal state shows at the ports within one cycle. A mistaken control state changes st_busy or st_done on the next edge. A write outside the capture states raises mem_we. A pointer or wrap fault moves st_wptr and mem_addr away from the expected offset on the first write that follows. A faulty edge detector or a wrong source select either ends the capture early or lets it run on after the trigger should have fired. A wrong post count shows up as done arriving on the wrong write. A pass through a full window in each window mode shows any error in the wrap limit.

// File: rtl/iq_cap_pkg.sv
package iq_cap_pkg;

  localparam int NUM_SRC = 6;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_PRE  = 2'd1,
    CAP_POST = 2'd2,
    CAP_DONE = 2'd3
  } cap_state_e;

  // Source index order within the event vector (matches cfg_trig_sel codes)
  localparam int SRC_MANUAL  = 0;
  localparam int SRC_CRC_OK  = 1;
  localparam int SRC_CRC_BAD = 2;
  localparam int SRC_CCA     = 3;
  localparam int SRC_BB      = 4;
  localparam int SRC_MAC     = 5;

  typedef struct packed {
    logic [2:0] sel;
    logic       falling;
    logic       dbl;
    logic       dual;
  } cap_cfg_t;

endpackage

// File: rtl/iq_cap_trig.sv
module iq_cap_trig #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic [2:0]         sel,
  input  logic               falling,
  input  logic               armed,
  output logic               hit
);

  logic [NUM_SRC-1:0] prev;
  logic [NUM_SRC-1:0] edg;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= src;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
    assign edg[g] = falling ? (prev[g] & ~src[g]) : (src[g] & ~prev[g]);
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(sel) == i) hit = armed & edg[i];
    end
  end

endmodule

// File: rtl/iq_cap_pack.sv
module iq_cap_pack #(
  parameter int SW      = 12,
  parameter bit DUAL_EN = 1'b1
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] a_q,
  input  logic [SW-1:0] b_i,
  input  logic [SW-1:0] b_q,
  input  logic          dual,
  output logic [63:0]   word
);

  localparam int PAD = 32 - 2 * SW;

  logic [31:0] lo_half;
  logic [31:0] hi_half;

  assign lo_half = {{PAD{1'b0}}, a_q, a_i};

  if (DUAL_EN) begin : g_dual
    assign hi_half = dual ? {{PAD{1'b0}}, b_i, b_q} : 32'd0;
  end else begin : g_single
    assign hi_half = 32'd0;
  end

  assign word = {hi_half, lo_half};

endmodule

// File: rtl/iq_cap_ring.sv
module iq_cap_ring #(
  parameter int WIN_WORDS = 4096,
  parameter int MEM_AW    = 14,
  parameter int WIN_BASE  = 4096,
  parameter int PTR_W     = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr,
  input  logic              dbl,
  input  logic [63:0]       din,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [PTR_W-1:0]  ptr
);

  localparam logic [PTR_W-1:0]  LAST_S = PTR_W'(WIN_WORDS - 1);
  localparam logic [PTR_W-1:0]  LAST_D = PTR_W'(2 * WIN_WORDS - 1);
  localparam logic [MEM_AW-1:0] BASE_A = MEM_AW'(WIN_BASE);

  logic [PTR_W-1:0] last;
  assign last = dbl ? LAST_D : LAST_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= BASE_A;
      mem_wdata <= '0;
    end else begin
      mem_we <= wr & ~clear;
      if (clear) begin
        ptr <= '0;
      end else if (wr) begin
        mem_addr  <= BASE_A + MEM_AW'(ptr);
        mem_wdata <= din;
        ptr       <= (ptr == last) ? '0 : ptr + PTR_W'(1);
      end
    end
  end

endmodule

// File: rtl/iq_capture_eng.sv
module iq_capture_eng #(
  parameter int SW        = 12,
  parameter int WIN_WORDS = 4096,
  parameter int MEM_AW    = 14,
  parameter int WIN_BASE  = 4096,
  parameter int POST_W    = 16,
  parameter bit DUAL_EN   = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_enable,
  input  logic [2:0]                     cfg_trig_sel,
  input  logic                           cfg_trig_falling,
  input  logic [POST_W-1:0]              cfg_post_cnt,
  input  logic                           cfg_win_double,
  input  logic                           cfg_dual_path,
  input  logic                           cfg_manual,
  input  logic                           smp_valid,
  input  logic [SW-1:0]                  smp_a_i,
  input  logic [SW-1:0]                  smp_a_q,
  input  logic [SW-1:0]                  smp_b_i,
  input  logic [SW-1:0]                  smp_b_q,
  input  logic                           ev_crc_ok,
  input  logic                           ev_crc_fail,
  input  logic                           ev_cca,
  input  logic                           ev_bb,
  input  logic                           ev_mac,
  output logic                           mem_we,
  output logic [MEM_AW-1:0]              mem_addr,
  output logic [63:0]                    mem_wdata,
  output logic                           st_busy,
  output logic                           st_done,
  output logic [$clog2(2*WIN_WORDS)-1:0] st_wptr
);
  import iq_cap_pkg::*;

  localparam int PTR_W = $clog2(2 * WIN_WORDS);

  cap_state_e          state;
  cap_cfg_t            cfg_q;
  logic [POST_W-1:0]   post_q;
  logic [POST_W-1:0]   post_left;
  logic [NUM_SRC-1:0]  src;
  logic [63:0]         word;
  logic                arm;
  logic                accept;
  logic                hit;

  always_comb begin
    src              = '0;
    src[SRC_MANUAL]  = cfg_manual;
    src[SRC_CRC_OK]  = ev_crc_ok;
    src[SRC_CRC_BAD] = ev_crc_fail;
    src[SRC_CCA]     = ev_cca;
    src[SRC_BB]      = ev_bb;
    src[SRC_MAC]     = ev_mac;
  end

  assign arm    = (state == CAP_IDLE) && cfg_enable;
  assign accept = smp_valid && ((state == CAP_PRE) || (state == CAP_POST));

  iq_cap_trig #(.NUM_SRC(NUM_SRC)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .src     (src),
    .sel     (cfg_q.sel),
    .falling (cfg_q.falling),
    .armed   (state == CAP_PRE),
    .hit     (hit)
  );

  iq_cap_pack #(.SW(SW), .DUAL_EN(DUAL_EN)) u_pack (
    .a_i  (smp_a_i),
    .a_q  (smp_a_q),
    .b_i  (smp_b_i),
    .b_q  (smp_b_q),
    .dual (cfg_q.dual),
    .word (word)
  );

  iq_cap_ring #(
    .WIN_WORDS (WIN_WORDS),
    .MEM_AW    (MEM_AW),
    .WIN_BASE  (WIN_BASE),
    .PTR_W     (PTR_W)
  ) u_ring (
    .clk       (clk),
    .rst       (rst),
    .clear     (arm),
    .wr        (accept),
    .dbl       (cfg_q.dbl),
    .din       (word),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ptr       (st_wptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CAP_IDLE;
      cfg_q     <= '0;
      post_q    <= '0;
      post_left <= '0;
    end else if (!cfg_enable) begin
      state <= CAP_IDLE;
    end else begin
      case (state)
        CAP_IDLE: begin
          state         <= CAP_PRE;
          cfg_q.sel     <= cfg_trig_sel;
          cfg_q.falling <= cfg_trig_falling;
          cfg_q.dbl     <= cfg_win_double;
          cfg_q.dual    <= cfg_dual_path;
          post_q        <= cfg_post_cnt;
        end
        CAP_PRE: begin
          if (hit) begin
            post_left <= post_q;
            state     <= (post_q == '0) ? CAP_DONE : CAP_POST;
          end
        end
        CAP_POST: begin
          if (smp_valid) begin
            post_left <= post_left - POST_W'(1);
            if (post_left == POST_W'(1)) state <= CAP_DONE;
          end
        end
        default: state <= CAP_DONE;
      endcase
    end
  end

  assign st_busy = (state == CAP_PRE) || (state == CAP_POST);
  assign st_done = (state == CAP_DONE);

endmodule

// File: rtl/iq_capture_eng_chk.sv
module iq_capture_eng_chk #(
  parameter int MEM_AW   = 14,
  parameter int WIN_BASE = 4096,
  parameter int PTR_W    = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_enable,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [63:0]       mem_wdata,
  input logic              st_busy,
  input logic              st_done,
  input logic [PTR_W-1:0]  st_wptr
);

  logic [MEM_AW-1:0] off;
  assign off = mem_addr - MEM_AW'(WIN_BASE);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!st_busy && !st_done && st_wptr == '0 && !mem_we));

  assert_write_follows_busy_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(st_busy));

  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (st_wptr == '0 || st_wptr == PTR_W'(off) + PTR_W'(1)));

  assert_pad_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata[31:24] == 8'd0 && mem_wdata[63:56] == 8'd0));

  assert_busy_done_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(st_busy && st_done));

  assert_done_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (st_done && $past(st_done)) |-> !mem_we);

  assert_done_ptr_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    (st_done && $past(st_done)) |-> $stable(st_wptr));

  assert_done_needs_disable_R12: assert property (@(posedge clk) disable iff (rst)
    $past(st_done) |-> !st_busy);

  assert_done_leaves_on_disable_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(st_done) && !$past(cfg_enable)) |-> !st_done);

endmodule

bind iq_capture_eng iq_capture_eng_chk #(
  .MEM_AW   (MEM_AW),
  .WIN_BASE (WIN_BASE),
  .PTR_W    ($clog2(2*WIN_WORDS))
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_enable (cfg_enable),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .st_busy    (st_busy),
  .st_done    (st_done),
  .st_wptr    (st_wptr)
);

// File: tb/iq_capture_eng_tb.sv
`timescale 1ns/1ps
module iq_capture_eng_tb;

  localparam int WIN    = 4096;
  localparam int MAW    = 14;
  localparam int BASE   = 4096;
  localparam int POSTW  = 16;
  localparam int PW     = $clog2(2*WIN);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 0, cfg_trig_falling = 0, cfg_win_double = 0, cfg_dual_path = 0, cfg_manual = 0;
  logic [2:0] cfg_trig_sel = 3'd0;
  logic [POSTW-1:0] cfg_post_cnt = '0;
  logic smp_valid = 0;
  logic [11:0] smp_a_i = 0, smp_a_q = 0, smp_b_i = 0, smp_b_q = 0;
  logic ev_crc_ok = 0, ev_crc_fail = 0, ev_cca = 0, ev_bb = 0, ev_mac = 0;
  logic mem_we, st_busy, st_done;
  logic [MAW-1:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [PW-1:0] st_wptr;

  always #2.5 clk = ~clk;

  iq_capture_eng u_dut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_trig_sel(cfg_trig_sel),
    .cfg_trig_falling(cfg_trig_falling), .cfg_post_cnt(cfg_post_cnt),
    .cfg_win_double(cfg_win_double), .cfg_dual_path(cfg_dual_path), .cfg_manual(cfg_manual),
    .smp_valid(smp_valid), .smp_a_i(smp_a_i), .smp_a_q(smp_a_q), .smp_b_i(smp_b_i),
    .smp_b_q(smp_b_q), .ev_crc_ok(ev_crc_ok), .ev_crc_fail(ev_crc_fail), .ev_cca(ev_cca),
    .ev_bb(ev_bb), .ev_mac(ev_mac), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .st_busy(st_busy), .st_done(st_done), .st_wptr(st_wptr)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 0;
  bit finished = 0;
  string cur_req = "R3";

  // Behavioural reference model: 0 idle, 1 pre, 2 post, 3 done
  int m_state = 0, m_ptr = 0, m_left = 0, m_post = 0, m_sel = 0;
  bit m_fall = 0, m_dbl = 0, m_dual = 0, m_we = 0;
  logic [5:0] m_prev = '0;
  int m_addr = 0;
  logic [63:0] m_data = '0;

  always @(posedge clk) begin
    logic [5:0] raw, edg;
    bit hit;
    raw = {ev_mac, ev_bb, ev_cca, ev_crc_fail, ev_crc_ok, cfg_manual};
    if (rst) begin
      m_state = 0; m_ptr = 0; m_we = 0; m_left = 0;
    end else begin
      edg = m_fall ? (m_prev & ~raw) : (raw & ~m_prev);
      hit = 0;
      if (m_state == 1 && m_sel < 6) hit = edg[m_sel];
      m_we = smp_valid && (m_state == 1 || m_state == 2);
      if (m_we) begin
        m_addr = BASE + m_ptr;
        m_data = 64'd0;
        m_data[11:0]  = smp_a_i;
        m_data[23:12] = smp_a_q;
        if (m_dual) begin
          m_data[43:32] = smp_b_q;
          m_data[55:44] = smp_b_i;
        end
        m_ptr = (m_ptr + 1) % (m_dbl ? 2*WIN : WIN);
      end
      if (!cfg_enable) m_state = 0;
      else if (m_state == 0) begin
        m_state = 1; m_ptr = 0; m_sel = int'(cfg_trig_sel); m_fall = cfg_trig_falling;
        m_dbl = cfg_win_double; m_dual = cfg_dual_path; m_post = int'(cfg_post_cnt);
      end else if (m_state == 1) begin
        if (hit) begin
          m_left = m_post;
          m_state = (m_post == 0) ? 3 : 2;
        end
      end else if (m_state == 2) begin
        if (smp_valid) begin
          m_left--;
          if (m_left == 0) m_state = 3;
        end
      end
    end
    m_prev = rst ? 6'd0 : raw;
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      n_checks++;
      if (st_busy !== (m_state == 1 || m_state == 2) || st_done !== (m_state == 3) ||
          int'(st_wptr) != m_ptr || mem_we !== m_we ||
          (m_we && (int'(mem_addr) != m_addr || mem_wdata !== m_data))) begin
        n_fail++;
        $display("FAIL %s model: busy=%0b done=%0b wptr=%0d we=%0b addr=%0d data=%h expected busy=%0b done=%0b wptr=%0d we=%0b addr=%0d data=%h",
                 cur_req, st_busy, st_done, st_wptr, mem_we, mem_addr, mem_wdata,
                 (m_state == 1 || m_state == 2), (m_state == 3), m_ptr, m_we, m_addr, m_data);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic feed(int n);
    for (int k = 0; k < n; k++) begin
      smp_valid = 1;
      smp_a_i = 12'($urandom); smp_a_q = 12'($urandom);
      smp_b_i = 12'($urandom); smp_b_q = 12'($urandom);
      cyc();
    end
    smp_valid = 0;
  endtask

  task automatic arm(logic [2:0] sel, int post, bit fall, bit dbl, bit dual);
    cfg_enable = 0; cyc();
    cfg_trig_sel = sel; cfg_post_cnt = POSTW'(post); cfg_trig_falling = fall;
    cfg_win_double = dbl; cfg_dual_path = dual;
    cfg_enable = 1; cyc();
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    cyc(190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc();
    cmp_on = 1;
    cur_req = "R1";
    chk("R1", {st_busy, st_done, mem_we}, 0);
    chk("R1", 64'(st_wptr), 0);

    // R2 / R3 / R4 / R10: manual trigger, post count 5
    cur_req = "R3";
    arm(3'd0, 5, 0, 0, 0);
    chk("R2", 64'(st_busy), 1);
    chk("R2", 64'(st_wptr), 0);
    smp_valid = 1; smp_a_i = 12'h123; smp_a_q = 12'h456; smp_b_i = 12'hABC; smp_b_q = 12'hDEF;
    cyc(); smp_valid = 0;
    chk("R4", mem_wdata, 64'h0000_0000_0045_6123);
    chk("R3", 64'(mem_addr), 64'(BASE));
    feed(9);
    cfg_post_cnt = 16'd1;               // R2: change after arm has no effect
    cfg_manual = 1; cyc(); cfg_manual = 0;
    feed(3); cyc(2); feed(1);
    chk("R10", {st_busy, st_done}, 2'b10);
    feed(1); feed(3);
    chk("R10", {st_busy, st_done}, 2'b01);
    chk("R10", 64'(st_wptr), 15);

    // R12: trigger ignored while done, disable clears, re-arm
    cur_req = "R12";
    cfg_manual = 1; cyc(); cfg_manual = 0; cyc();
    chk("R12", {st_done, 7'(st_wptr)}, {1'b1, 7'd15});
    cfg_enable = 0; cyc();
    chk("R12", {st_busy, st_done}, 2'b00);
    cfg_enable = 1; cyc();
    chk("R12", {st_busy, 14'(st_wptr)}, {1'b1, 14'd0});

    // R9: level high at arm does not trigger; edge while armed does
    cur_req = "R9";
    cfg_enable = 0; cfg_manual = 1; cyc();
    arm(3'd0, 0, 0, 0, 0);
    feed(5);
    chk("R9", {st_busy, st_done}, 2'b10);
    cfg_manual = 0; cyc(); cfg_manual = 1; cyc(); cfg_manual = 0; cyc();
    chk("R9", {st_busy, st_done}, 2'b01);

    // R7: only the selected source counts; codes 6 and 7 never fire
    cur_req = "R7";
    arm(3'd3, 2, 0, 0, 0);
    ev_crc_ok = 1; ev_mac = 1; ev_bb = 1; cfg_manual = 1; cyc();
    ev_crc_ok = 0; ev_mac = 0; ev_bb = 0; cfg_manual = 0;
    feed(3);
    chk("R7", {st_busy, st_done}, 2'b10);
    ev_cca = 1; cyc(); ev_cca = 0;
    feed(2);
    chk("R7", {st_done, 14'(st_wptr)}, {1'b1, 14'd5});
    arm(3'd6, 0, 0, 0, 0);
    ev_crc_ok = 1; ev_crc_fail = 1; ev_cca = 1; ev_bb = 1; ev_mac = 1; cfg_manual = 1; cyc();
    ev_crc_ok = 0; ev_crc_fail = 0; ev_cca = 0; ev_bb = 0; ev_mac = 0; cfg_manual = 0;
    feed(4);
    chk("R7", {st_busy, st_done}, 2'b10);

    // R8: falling polarity ignores a rise, fires on a fall
    cur_req = "R8";
    arm(3'd1, 1, 1, 0, 0);
    ev_crc_ok = 1; cyc();
    feed(3);
    chk("R8", {st_busy, st_done}, 2'b10);
    ev_crc_ok = 0; cyc();
    feed(1);
    chk("R8", {st_busy, st_done}, 2'b01);

    // R2: post count latched at arm
    cur_req = "R2";
    arm(3'd0, 4, 0, 0, 0);
    cfg_post_cnt = 16'd1; cfg_trig_sel = 3'd2;
    cfg_manual = 1; cyc(); cfg_manual = 0;
    feed(1);
    chk("R2", {st_busy, st_done}, 2'b10);
    feed(3);
    chk("R2", {st_busy, st_done}, 2'b01);

    // R11: no samples after trigger keeps busy
    cur_req = "R11";
    arm(3'd0, 3, 0, 0, 0);
    cfg_manual = 1; cyc(); cfg_manual = 0;
    cyc(60);
    chk("R11", {st_busy, st_done}, 2'b10);

    // R5: dual path packing
    cur_req = "R5";
    arm(3'd0, 2, 0, 0, 1);
    smp_valid = 1; smp_a_i = 12'h123; smp_a_q = 12'h456; smp_b_i = 12'hABC; smp_b_q = 12'hDEF;
    cyc(); smp_valid = 0;
    chk("R5", mem_wdata, 64'h00AB_CDEF_0045_6123);
    feed(8);

    // R6: wrap in single and doubled windows
    cur_req = "R6";
    arm(3'd0, 2, 0, 0, 0);
    feed(4100);
    cfg_manual = 1; cyc(); cfg_manual = 0;
    feed(2);
    chk("R6", {st_done, 14'(st_wptr)}, {1'b1, 14'd6});
    arm(3'd0, 2, 0, 1, 0);
    feed(8200);
    cfg_manual = 1; cyc(); cfg_manual = 0;
    feed(2);
    chk("R6", {st_done, 14'(st_wptr)}, {1'b1, 14'd10});

    cfg_enable = 0; cyc(3);
    summary();
  end

endmodule